// File: doc/BRIEF.md
# Grouped Data Bus Inversion Codec

This block sits between a core's logical data words and an active-low, quad-pumped 64-bit data bus. On such a bus a logical 1 is carried by pulling a line electrically low. Each 64-bit transfer splits into four 16-bit groups. For each group the encoder decides on its own whether to send the group inverted, so that no more than half of the group's lines are ever pulled low. Next to the electrical levels it drives one inversion flag per group. The flags are also active low.

One bus clock carries four transfer slots, and each slot makes its own decision. The encoder takes all four slots of logical data at once. It returns the registered bus levels and sixteen flags one clock later. The decoder does the reverse: it takes bus levels and flags and returns the logical words one clock later. Both halves follow their own data-ready qualifier. When that qualifier is low, the half's outputs keep their last values, so idle clocks can sit inside a multi-clock burst.

Top module: `dbi_codec`

## Requirements
- R1: Slot s occupies bits [64*s+63 : 64*s] of every 256-bit port. Within a slot, group k is bits [16*k+15 : 16*k], and its flag is bit 4*s+k of the flag port, so flag 0 belongs to bits 15..0 of slot 0.
- R2: When a group's logical word has 9 or more ones, the encoder drives the levels equal to the logical bits and drives the group's flag low (0 = inverted).
- R3: When a group has 8 or fewer ones, including exactly 8, the encoder drives the levels equal to the bitwise complement of the logical bits and drives the flag high.
- R4: No encoded group ever has more than 8 of its 16 level bits at 0 (electrically low).
- R5: The decoder returns the level bits unchanged for a group whose flag is 0, and returns their complement for a group whose flag is 1.
- R6: Each half has one clock of latency. Its output-valid signal equals its input qualifier from the previous clock.
- R7: While a half's input qualifier is low, that half's outputs (levels and flags, or decoded data) stay unchanged, whatever data is on its inputs.
- R8: After reset, the bus levels and flags are all 1, both valid outputs are 0, and the decoded data is all 0.
- R9: Each of the four slots and each group within a slot is decided independently: neighbouring groups with different ones counts get different decisions in the same clock.
- R10: Passing the encoder's levels and flags through the decoder returns the original logical word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous reset, active low |
| encValid | input | 1 | Data-ready qualifier for the encoder input |
| encData | input | 256 | Logical data, four slots of 64 bits |
| busValid | output | 1 | Encoder output valid, one clock after encValid |
| busLevel | output | 256 | Electrical levels to drive (0 = line low) |
| busFlagN | output | 16 | Per-group inversion flags, 0 = inverted |
| decValid | input | 1 | Data-ready qualifier for the decoder input |
| decLevel | input | 256 | Electrical levels sampled from the bus |
| decFlagN | input | 16 | Sampled inversion flags, 0 = inverted |
| decDataValid | output | 1 | Decoder output valid, one clock after decValid |
| decData | output | 256 | Restored logical data |

## Verification
The embedded properties check four things on every clock. No registered group shows more than eight low lines. An inverted group always shows fewer than eight. Both valid outputs trail their qualifiers by exactly one clock. The registered levels, flags and decoded words stay frozen across idle clocks. Only the scenarios can show that the decision falls on the correct side of the 8/9 boundary for each group and slot, that the bit-to-flag mapping is right, and that the loopback through the decoder returns the original word, because each of these needs a reference computed from the input data.

// File: rtl/dbi_pkg.sv
package dbi_pkg;
  // Load strobes issued by the control block to the datapath registers.
  typedef struct packed {
    logic loadEnc;
    logic loadDec;
  } dbiStrobes_t;
endpackage

// File: rtl/dbi_group_enc.sv
// Per-group inversion decision for an active-low bus: a logical 1 costs a low line.
module dbi_group_enc #(
  parameter int GROUP_W = 16
) (
  input  logic [GROUP_W-1:0] logicalIn,
  output logic [GROUP_W-1:0] levelOut,
  output logic               invertN
);
  localparam int CNT_W = $clog2(GROUP_W + 1);
  localparam int HALF  = GROUP_W / 2;

  logic [CNT_W-1:0] onesCnt;
  logic             doInvert;

  always_comb begin
    onesCnt = '0;
    for (int i = 0; i < GROUP_W; i++) onesCnt = onesCnt + CNT_W'(logicalIn[i]);
  end

  // Strictly more than half low: invert so the driven lows become the zeros.
  assign doInvert = onesCnt > CNT_W'(HALF);
  assign levelOut = doInvert ? logicalIn : ~logicalIn;
  assign invertN  = ~doInvert;
endmodule

// File: rtl/dbi_ctrl.sv
// Control: turns the two data-ready qualifiers into load strobes and valid flags.
module dbi_ctrl
  import dbi_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        encValid,
  input  logic        decValid,
  output dbiStrobes_t strobes,
  output logic        encValidQ,
  output logic        decValidQ
);
  assign strobes.loadEnc = encValid;
  assign strobes.loadDec = decValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      encValidQ <= 1'b0;
      decValidQ <= 1'b0;
    end else begin
      encValidQ <= encValid;
      decValidQ <= decValid;
    end
  end

  // R6: each output valid trails its qualifier by one clock
  a_r6_enc_latency: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> encValidQ == $past(encValid));
  a_r6_dec_latency: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> decValidQ == $past(decValid));
endmodule

// File: rtl/dbi_datapath.sv
// Datapath: per-group encoders, decoders and the output registers.
module dbi_datapath
  import dbi_pkg::*;
#(
  parameter int SLOTS   = 4,
  parameter int GROUPS  = 4,
  parameter int GROUP_W = 16
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  dbiStrobes_t                        strobes,
  input  logic [SLOTS*GROUPS*GROUP_W-1:0]    encData,
  input  logic [SLOTS*GROUPS*GROUP_W-1:0]    decLevel,
  input  logic [SLOTS*GROUPS-1:0]            decFlagN,
  output logic [SLOTS*GROUPS*GROUP_W-1:0]    busLevelQ,
  output logic [SLOTS*GROUPS-1:0]            busFlagNQ,
  output logic [SLOTS*GROUPS*GROUP_W-1:0]    decDataQ
);
  localparam int FLAG_W = SLOTS * GROUPS;
  localparam int BUS_W  = FLAG_W * GROUP_W;
  localparam int CNT_W  = $clog2(GROUP_W + 1);
  localparam int HALF   = GROUP_W / 2;

  logic [BUS_W-1:0]  encLevelD;
  logic [FLAG_W-1:0] encFlagD;
  logic [BUS_W-1:0]  decDataD;

  // Flat group index g = slot*GROUPS + group; bits [g*GROUP_W +: GROUP_W].
  for (genvar g = 0; g < FLAG_W; g++) begin : gGroup
    dbi_group_enc #(.GROUP_W(GROUP_W)) u_enc (
      .logicalIn (encData[g*GROUP_W +: GROUP_W]),
      .levelOut  (encLevelD[g*GROUP_W +: GROUP_W]),
      .invertN   (encFlagD[g])
    );

    // A flag at 0 means the levels already carry the data active-high.
    assign decDataD[g*GROUP_W +: GROUP_W] = decFlagN[g]
      ? ~decLevel[g*GROUP_W +: GROUP_W]
      :  decLevel[g*GROUP_W +: GROUP_W];

    logic [CNT_W-1:0] lowCnt;
    always_comb begin
      lowCnt = '0;
      for (int i = 0; i < GROUP_W; i++)
        lowCnt = lowCnt + CNT_W'(~busLevelQ[g*GROUP_W + i]);
    end

    // R4: never more than half of a group's lines low
    a_r4_low_limit: assert property (@(posedge clk) disable iff (!rstN)
      lowCnt <= CNT_W'(HALF));
    // R2: an inverted group came from a majority of ones, so fewer than half are low
    a_r2_inverted_low: assert property (@(posedge clk) disable iff (!rstN)
      !busFlagNQ[g] |-> lowCnt < CNT_W'(HALF));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busLevelQ <= '1;
      busFlagNQ <= '1;
    end else if (strobes.loadEnc) begin
      busLevelQ <= encLevelD;
      busFlagNQ <= encFlagD;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) decDataQ <= '0;
    else if (strobes.loadDec) decDataQ <= decDataD;
  end

  // R7: outputs frozen on clocks without a load strobe
  a_r7_enc_hold: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && !$past(strobes.loadEnc) |-> $stable(busLevelQ) && $stable(busFlagNQ));
  a_r7_dec_hold: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && !$past(strobes.loadDec) |-> $stable(decDataQ));
endmodule

// File: rtl/dbi_codec.sv
// Thin top: quad-pumped grouped data bus inversion encoder and decoder.
module dbi_codec
  import dbi_pkg::*;
#(
  parameter int SLOTS   = 4,
  parameter int GROUPS  = 4,
  parameter int GROUP_W = 16,
  localparam int FLAG_W = SLOTS * GROUPS,
  localparam int BUS_W  = FLAG_W * GROUP_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              encValid,
  input  logic [BUS_W-1:0]  encData,
  output logic              busValid,
  output logic [BUS_W-1:0]  busLevel,
  output logic [FLAG_W-1:0] busFlagN,
  input  logic              decValid,
  input  logic [BUS_W-1:0]  decLevel,
  input  logic [FLAG_W-1:0] decFlagN,
  output logic              decDataValid,
  output logic [BUS_W-1:0]  decData
);
  dbiStrobes_t strobes;

  dbi_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .encValid  (encValid),
    .decValid  (decValid),
    .strobes   (strobes),
    .encValidQ (busValid),
    .decValidQ (decDataValid)
  );

  dbi_datapath #(
    .SLOTS   (SLOTS),
    .GROUPS  (GROUPS),
    .GROUP_W (GROUP_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .encData   (encData),
    .decLevel  (decLevel),
    .decFlagN  (decFlagN),
    .busLevelQ (busLevel),
    .busFlagNQ (busFlagN),
    .decDataQ  (decData)
  );
endmodule

// File: tb/dbi_codec_tb.sv
module dbi_codec_tb;
  localparam int BUS_W  = 256;
  localparam int FLAG_W = 16;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              encValid = 1'b0;
  logic [BUS_W-1:0]  encData = '0;
  logic              busValid;
  logic [BUS_W-1:0]  busLevel;
  logic [FLAG_W-1:0] busFlagN;
  logic              decDataValid;
  logic [BUS_W-1:0]  decData;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  logic [BUS_W-1:0]  qLevel[$];
  logic [FLAG_W-1:0] qFlag[$];
  logic [BUS_W-1:0]  qData[$];
  logic [BUS_W-1:0]  lastLevel = '1;
  logic [FLAG_W-1:0] lastFlag = '1;
  logic [BUS_W-1:0]  lastData = '0;

  always #4 clk = ~clk; // 125 MHz

  // R10: decoder fed in loopback from the encoder outputs
  dbi_codec u_dut (
    .clk(clk), .rstN(rstN),
    .encValid(encValid), .encData(encData),
    .busValid(busValid), .busLevel(busLevel), .busFlagN(busFlagN),
    .decValid(busValid), .decLevel(busLevel), .decFlagN(busFlagN),
    .decDataValid(decDataValid), .decData(decData)
  );

  task automatic check(input bit ok, input string req, input logic [BUS_W-1:0] act,
                       input logic [BUS_W-1:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Reference model built from R1..R3: 16 groups, flag index = group index.
  task automatic drive(input logic [BUS_W-1:0] w);
    logic [BUS_W-1:0] lv;
    logic [FLAG_W-1:0] fl;
    for (int g = 0; g < FLAG_W; g++) begin
      logic [15:0] grp;
      int ones;
      grp = w[g*16 +: 16];
      ones = $countones(grp);
      if (ones > 8) begin lv[g*16 +: 16] = grp;  fl[g] = 1'b0; end // R2
      else          begin lv[g*16 +: 16] = ~grp; fl[g] = 1'b1; end // R3
    end
    @(negedge clk);
    encValid = 1'b1;
    encData  = w;
    qLevel.push_back(lv);
    qFlag.push_back(fl);
    qData.push_back(w);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      encValid = 1'b0;
      encData  = {8{$urandom()}}; // R7: junk while idle
    end
  endtask

  function automatic logic [15:0] onesGrp(input int n, input int rot);
    logic [31:0] b;
    b = (n >= 16) ? 32'hFFFF : ((32'd1 << n) - 1);
    b = (b << (rot % 16)) | (b >> (16 - (rot % 16)));
    return b[15:0];
  endfunction

  // Monitor: scoreboard compare after each edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (rstN && !done) begin
        if (busValid) begin
          logic [BUS_W-1:0] el;
          logic [FLAG_W-1:0] ef;
          el = qLevel.pop_front();
          ef = qFlag.pop_front();
          check(busLevel == el, "R1/R2/R3 levels", busLevel, el);
          check(busFlagN == ef, "R1/R9 flags", BUS_W'(busFlagN), BUS_W'(ef));
          for (int g = 0; g < FLAG_W; g++) begin
            int lows;
            lows = 16 - $countones(busLevel[g*16 +: 16]);
            check(lows <= 8, "R4 low count", BUS_W'(lows), BUS_W'(8));
          end
          lastLevel = busLevel;
          lastFlag  = busFlagN;
        end else begin
          check(busLevel == lastLevel && busFlagN == lastFlag, "R7 encoder hold",
                busLevel, lastLevel);
        end
        if (decDataValid) begin
          logic [BUS_W-1:0] ed;
          ed = qData.pop_front();
          check(decData == ed, "R5/R10 round trip", decData, ed);
          lastData = decData;
        end else begin
          check(decData == lastData, "R7 decoder hold", decData, lastData);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [BUS_W-1:0] w;
    repeat (3) @(negedge clk);
    // R8: reset values
    check(busLevel == '1, "R8 levels", busLevel, '1);
    check(busFlagN == '1, "R8 flags", BUS_W'(busFlagN), BUS_W'(16'hFFFF));
    check(!busValid && !decDataValid, "R8 valids", BUS_W'({busValid, decDataValid}), '0);
    check(decData == '0, "R8 data", decData, '0);
    rstN = 1'b1;
    @(negedge clk);
    drive('0);          // R3: all groups 0 ones
    drive('1);          // R2: all groups 16 ones
    // R3 boundary exactly 8, R2 boundary exactly 9, alternating groups (R9)
    for (int g = 0; g < FLAG_W; g++) w[g*16 +: 16] = onesGrp((g % 2) ? 9 : 8, g);
    drive(w);
    for (int g = 0; g < FLAG_W; g++) w[g*16 +: 16] = onesGrp((g % 2) ? 8 : 9, g + 3);
    drive(w);
    idle(3);            // R7
    // R1/R9: only one group per slot above half, position walks with slot
    for (int g = 0; g < FLAG_W; g++) w[g*16 +: 16] = onesGrp(((g % 4) == (g / 4)) ? 12 : 4, g);
    drive(w);
    // every count 0..15 once across the 16 groups
    for (int g = 0; g < FLAG_W; g++) w[g*16 +: 16] = onesGrp(g, 5 * g);
    drive(w);
    idle(1);
    for (int i = 0; i < 30; i++) begin
      drive({8{$urandom()}});
      if (i % 7 == 3) idle(2);
    end
    idle(4);
    done = 1'b1;
    check(qLevel.size() == 0 && qData.size() == 0, "R6 all results seen",
          BUS_W'(qLevel.size() + qData.size()), '0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule